// File: doc/BRIEF.md
# Quad Wiper Serial Control Front End

This block is the digital side of a four-channel digital resistor. A host drives a three-wire serial port: a serial clock, an active-low select and a data line. While the select is low, each rising edge of the serial clock moves one bit into a ten-bit shift register. When the select goes high, the two oldest bits of that register choose one of four eight-bit wiper latches, and the other eight bits are written into it. The resistor array reads the latch values from the outputs.

The shift register also works as a ten-stage delay line. Every bit it pushes out lands on an open-drain style serial output, so several devices can be chained from one host data line. A chain of two devices is loaded by keeping the select low for twenty serial clocks. An active-low reset sets all wipers to midscale. An active-low shutdown releases the serial output and raises a flag toward the resistor array, but it leaves the wiper values alone.

All serial pins are sampled by a free-running core clock through a parameterised synchroniser, and the block acts on the edges it detects there. Reset acts asynchronously. Shutdown acts directly at the pins.

Top module: `pot_serial_ctrl`

## Requirements
- R1: While `rs_n_i` is low, every wiper slice reads 0x80 and `sdo_pull_low_o` is 0. After reset is released, the output latch is cleared, so `sdo_pull_low_o` reads 1 until new bits are shifted.
- R2: Each rising `sclk_i` edge seen while `cs_n_i` is low shifts `sdi_i` into the register, most significant bit first. A complete word is {A1, A0, D7..D0}, and A1 is the first bit sent.
- R3: A rising edge of `cs_n_i` writes the register's low eight bits into the wiper chosen by the two address bits: 0 selects bits [7:0] of `wiper_o`, 1 selects [15:8], 2 selects [23:16] and 3 selects [31:24]. The new value appears on the third core clock edge after the pin change.
- R4: A load changes only the addressed wiper. The other three keep their values.
- R5: Serial clock edges that arrive while `cs_n_i` is high leave the shift register unchanged. A later select pulse with no clocks therefore writes the previously shifted word again.
- R6: After each shift, `sdo_pull_low_o` is the inverse of the bit that entered ten shifts earlier, or 1 if no such bit has entered since reset. This holds only while reset and shutdown are both inactive.
- R7: While `shdn_n_i` is low, `shutdown_o` is 1 and `sdo_pull_low_o` is 0. Shutdown does not alter the wiper values, and shifting and loading still work.
- R8: Reset wins over a select rising edge that arrives at the same time. The wipers end at midscale.
- R9: With the select held low for twenty clocks, the device loads the last ten bits. The first ten bits leave on the serial output during clocks 11 to 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core sampling clock |
| rs_n_i | input | 1 | Active-low reset to midscale, asynchronous |
| sclk_i | input | 1 | Serial clock |
| cs_n_i | input | 1 | Active-low select; its rising edge loads a wiper |
| sdi_i | input | 1 | Serial data in |
| shdn_n_i | input | 1 | Active-low shutdown |
| wiper_o | output | 32 | Four 8-bit wiper values, channel 0 in the low byte |
| shutdown_o | output | 1 | Shutdown flag toward the resistor array |
| sdo_pull_low_o | output | 1 | Serial output driver enable; 1 pulls the line low |

## Verification
A pin change reaches the detected-edge wires after two core edges. The register or latch it drives updates on the third core edge. So a shifted bit and its serial output, and a wiper load, are all due three core edges after the serial clock or select edge. Shutdown and reset reach the serial output in the same cycle, because they gate the pin directly. The bench drives pins at falling core edges and holds each level for four core cycles before it samples. The latency check samples a wiper after exactly two core edges, where it must still be old, and again after the third, where it must be new.

// File: rtl/pot_pkg.sv
package pot_pkg;

  // Midscale code for a wiper of the given width: only the top bit set.
  function automatic logic [31:0] midscale_of(int unsigned width);
    return 32'(1) << (width - 1);
  endfunction

  // True when a decoded address selects the given channel.
  function automatic logic addr_hits(int unsigned addr, int unsigned ch);
    return addr == ch;
  endfunction

  // Serial output drive enable for the open-drain pin model.
  function automatic logic pull_low_of(logic rs_n, logic shdn_n, logic bit_q);
    return rs_n & shdn_n & ~bit_q;
  endfunction

endpackage

// File: rtl/pot_pin_sync.sv
module pot_pin_sync #(
  parameter int               WIDTH     = 3,
  parameter int               STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);

  // STAGES must be at least 2; the chain is one packed shift per pin.
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      stg_q <= {STAGES{RESET_VAL}};
    end else begin
      stg_q <= {stg_q[STAGES-2:0], din_i};
    end
  end

  assign dout_o = stg_q[STAGES-1];

endmodule

// File: rtl/pot_shifter.sv
module pot_shifter #(
  parameter int WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              shift_en_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              sdo_q_o
);

  logic [WORD_W-1:0] sr_q;
  logic              sdo_q;

  // The oldest bit leaves into the output latch as each new bit enters.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sr_q  <= '0;
      sdo_q <= 1'b0;
    end else if (shift_en_i) begin
      sr_q  <= {sr_q[WORD_W-2:0], sdi_i};
      sdo_q <= sr_q[WORD_W-1];
    end
  end

  assign word_o  = sr_q;
  assign sdo_q_o = sdo_q;

endmodule

// File: rtl/pot_wiper_bank.sv
module pot_wiper_bank #(
  parameter int CHANNELS = 4,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_n_i,
  input  logic                       load_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          data_i,
  output logic [CHANNELS*DATA_W-1:0] wiper_o,
  output logic [CHANNELS-1:0]        sel_o
);

  localparam logic [DATA_W-1:0] MID = DATA_W'(pot_pkg::midscale_of(DATA_W));

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    logic [DATA_W-1:0] val_q;

    assign sel_o[c] = load_i & pot_pkg::addr_hits(32'(addr_i), c);

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
        val_q <= MID;
      end else if (sel_o[c]) begin
        val_q <= data_i;
      end
    end

    assign wiper_o[c*DATA_W +: DATA_W] = val_q;
  end

endmodule

// File: rtl/pot_serial_ctrl.sv
module pot_serial_ctrl #(
  parameter int CHANNELS    = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rs_n_i,
  input  logic                       sclk_i,
  input  logic                       cs_n_i,
  input  logic                       sdi_i,
  input  logic                       shdn_n_i,
  output logic [CHANNELS*DATA_W-1:0] wiper_o,
  output logic                       shutdown_o,
  output logic                       sdo_pull_low_o
);

  localparam int ADDR_W = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;
  localparam int WORD_W = ADDR_W + DATA_W;

  // Synchronised pin levels: {sclk, cs_n, sdi}; select idles high.
  logic [2:0] pins_s;
  logic       sclk_s, cs_n_s, sdi_s;
  logic       sclk_prev_q, cs_prev_q;

  // Named internal events.
  logic              sclk_rise;
  logic              cs_rise;
  logic              shift_en;
  logic              load_en;
  logic [WORD_W-1:0] sr_word;
  logic              sdo_q;
  logic [CHANNELS-1:0] load_sel;

  pot_pin_sync #(
    .WIDTH    (3),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(3'b010)
  ) sync_i (
    .clk_i  (clk_i),
    .rst_n_i(rs_n_i),
    .din_i  ({sclk_i, cs_n_i, sdi_i}),
    .dout_o (pins_s)
  );

  assign sclk_s = pins_s[2];
  assign cs_n_s = pins_s[1];
  assign sdi_s  = pins_s[0];

  always_ff @(posedge clk_i or negedge rs_n_i) begin
    if (!rs_n_i) begin
      sclk_prev_q <= 1'b0;
      cs_prev_q   <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_s;
      cs_prev_q   <= cs_n_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign cs_rise   = cs_n_s & ~cs_prev_q;
  assign shift_en  = sclk_rise & ~cs_n_s;
  assign load_en   = cs_rise;

  pot_shifter #(
    .WORD_W(WORD_W)
  ) shift_i (
    .clk_i     (clk_i),
    .rst_n_i   (rs_n_i),
    .shift_en_i(shift_en),
    .sdi_i     (sdi_s),
    .word_o    (sr_word),
    .sdo_q_o   (sdo_q)
  );

  pot_wiper_bank #(
    .CHANNELS(CHANNELS),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) bank_i (
    .clk_i  (clk_i),
    .rst_n_i(rs_n_i),
    .load_i (load_en),
    .addr_i (sr_word[WORD_W-1 -: ADDR_W]),
    .data_i (sr_word[DATA_W-1:0]),
    .wiper_o(wiper_o),
    .sel_o  (load_sel)
  );

  assign shutdown_o     = ~shdn_n_i;
  assign sdo_pull_low_o = pot_pkg::pull_low_of(rs_n_i, shdn_n_i, sdo_q);

endmodule

// File: rtl/pot_serial_ctrl_chk.sv
module pot_serial_ctrl_chk #(
  parameter int CHANNELS = 4,
  parameter int DATA_W   = 8,
  parameter int WORD_W   = 10
) (
  input logic                       clk_i,
  input logic                       rs_n_i,
  input logic                       shdn_n_i,
  input logic                       sdi_s,
  input logic                       shift_en,
  input logic                       load_en,
  input logic [CHANNELS-1:0]        load_sel,
  input logic [WORD_W-1:0]          sr_word,
  input logic                       sdo_q,
  input logic [CHANNELS*DATA_W-1:0] wiper_o,
  input logic                       shutdown_o,
  input logic                       sdo_pull_low_o
);

  localparam logic [DATA_W-1:0] MID = DATA_W'(pot_pkg::midscale_of(DATA_W));
  localparam logic [CHANNELS*DATA_W-1:0] MID_ALL = {CHANNELS{MID}};
  localparam int ADDR_W = WORD_W - DATA_W;

  // R1
  reset_midscale_chk: assert property (@(posedge clk_i)
    (!rs_n_i && $past(!rs_n_i)) |-> (wiper_o == MID_ALL && !sdo_pull_low_o));

  // R2
  shift_entry_chk: assert property (@(posedge clk_i) disable iff (!rs_n_i)
    shift_en |=> sr_word[0] == $past(sdi_s));

  // R5
  shift_hold_chk: assert property (@(posedge clk_i) disable iff (!rs_n_i)
    !shift_en |=> $stable(sr_word));

  // R3
  load_target_chk: assert property (@(posedge clk_i) disable iff (!rs_n_i)
    load_en |=> wiper_o[32'($past(sr_word[WORD_W-1 -: ADDR_W]))*DATA_W +: DATA_W]
                == $past(sr_word[DATA_W-1:0]));

  // R4
  load_single_chk: assert property (@(posedge clk_i) disable iff (!rs_n_i)
    load_en |-> $countones(load_sel) == 1);

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rs_n_i)
    !load_en |=> $stable(wiper_o));

  // R6
  sdo_delay_chk: assert property (@(posedge clk_i) disable iff (!rs_n_i)
    shift_en |=> sdo_q == $past(sr_word[WORD_W-1]));

  // R7
  shutdown_release_chk: assert property (@(posedge clk_i) disable iff (!rs_n_i)
    !shdn_n_i |-> (shutdown_o && !sdo_pull_low_o));

  // R4
  sel_idle_chk: assert property (@(posedge clk_i) disable iff (!rs_n_i)
    $onehot0(load_sel));

endmodule

bind pot_serial_ctrl pot_serial_ctrl_chk #(
  .CHANNELS(CHANNELS),
  .DATA_W  (DATA_W),
  .WORD_W  (WORD_W)
) chk_i (
  .clk_i         (clk_i),
  .rs_n_i        (rs_n_i),
  .shdn_n_i      (shdn_n_i),
  .sdi_s         (sdi_s),
  .shift_en      (shift_en),
  .load_en       (load_en),
  .load_sel      (load_sel),
  .sr_word       (sr_word),
  .sdo_q         (sdo_q),
  .wiper_o       (wiper_o),
  .shutdown_o    (shutdown_o),
  .sdo_pull_low_o(sdo_pull_low_o)
);

// File: tb/pot_serial_ctrl_tb_top.sv
module pot_serial_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 4;
  localparam int NVEC       = 6;

  logic        clk = 1'b0;
  logic        rs_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  logic        shdn_n = 1'b1;
  logic [31:0] wiper;
  logic        shutdown;
  logic        pull_low;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model, written from the requirements.
  logic [7:0] m_wiper [4];
  logic [9:0] m_sr;
  logic       m_sdo;

  // Stimulus words {addr[1:0], data[7:0]}, loaded in order.
  localparam logic [9:0] VEC [NVEC] = '{
    {2'd0, 8'h3C}, {2'd1, 8'hA5}, {2'd2, 8'h00},
    {2'd3, 8'hFF}, {2'd1, 8'h01}, {2'd0, 8'hC3}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  pot_serial_ctrl dut_i (
    .clk_i         (clk),
    .rs_n_i        (rs_n),
    .sclk_i        (sclk),
    .cs_n_i        (cs_n),
    .sdi_i         (sdi),
    .shdn_n_i      (shdn_n),
    .wiper_o       (wiper),
    .shutdown_o    (shutdown),
    .sdo_pull_low_o(pull_low)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_reset();
    for (int c = 0; c < 4; c++) m_wiper[c] = 8'h80;
    m_sr  = '0;
    m_sdo = 1'b0;
  endtask

  task automatic check_wipers(input string req);
    for (int c = 0; c < 4; c++)
      check(wiper[c*8 +: 8] == m_wiper[c], req, $sformatf("wiper%0d", c),
            int'(wiper[c*8 +: 8]), int'(m_wiper[c]));
  endtask

  task automatic check_sdo(input string req);
    logic exp;
    exp = rs_n & shdn_n & ~m_sdo;
    check(pull_low == exp, req, "sdo_pull_low", int'(pull_low), int'(exp));
  endtask

  task automatic sclk_bit(input logic b, input string req);
    @(negedge clk);
    sdi = b;
    wait_neg(HOLD);
    sclk = 1'b1;
    if (!cs_n) begin
      m_sdo = m_sr[9];
      m_sr  = {m_sr[8:0], b};
    end
    wait_neg(HOLD);
    sclk = 1'b0;
    check_sdo(req);
  endtask

  task automatic send_word(input logic [9:0] w, input string req);
    for (int i = 9; i >= 0; i--) sclk_bit(w[i], req);
  endtask

  task automatic select_low();
    @(negedge clk);
    cs_n = 1'b0;
    wait_neg(HOLD);
  endtask

  task automatic select_high_load();
    @(negedge clk);
    cs_n = 1'b1;
    wait_neg(HOLD);
    m_wiper[m_sr[9:8]] = m_sr[7:0];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    wait_neg(5);
    // R1: reset state
    check_wipers("R1");
    check(pull_low == 1'b0, "R1", "pull_low in reset", int'(pull_low), 0);
    check(shutdown == 1'b0, "R1", "shutdown flag", int'(shutdown), 0);
    @(negedge clk);
    rs_n = 1'b1;
    wait_neg(2);
    check(pull_low == 1'b1, "R1", "cleared sdo latch", int'(pull_low), 1);

    // R2 R3 R4: table of words, with a latency check on the first one
    for (int v = 0; v < NVEC; v++) begin
      select_low();
      send_word(VEC[v], "R6");
      if (v == 0) begin
        @(negedge clk);
        cs_n = 1'b1;
        wait_neg(2);
        check(wiper[7:0] == 8'h80, "R3", "wiper0 before third edge",
              int'(wiper[7:0]), 8'h80);
        wait_neg(1);
        check(wiper[7:0] == VEC[v][7:0], "R3", "wiper0 at third edge",
              int'(wiper[7:0]), int'(VEC[v][7:0]));
        wait_neg(HOLD);
        m_wiper[m_sr[9:8]] = m_sr[7:0];
      end else begin
        select_high_load();
      end
      check(wiper[VEC[v][9:8]*8 +: 8] == VEC[v][7:0], "R2",
            "addressed wiper", int'(wiper[VEC[v][9:8]*8 +: 8]), int'(VEC[v][7:0]));
      check_wipers("R4");
    end

    // R5: clocks with select high are ignored; empty pulse reloads old word
    send_word({2'd3, 8'h55}, "R5");
    select_low();
    select_high_load();
    check_wipers("R5");
    check(wiper[31:24] == 8'hFF, "R5", "wiper3 untouched", int'(wiper[31:24]), 8'hFF);

    // R7: shutdown releases the output and keeps wipers
    @(negedge clk);
    shdn_n = 1'b0;
    @(negedge clk);
    check(shutdown == 1'b1, "R7", "shutdown flag", int'(shutdown), 1);
    check(pull_low == 1'b0, "R7", "released in shutdown", int'(pull_low), 0);
    check_wipers("R7");
    select_low();
    send_word({2'd2, 8'h5A}, "R7");
    select_high_load();
    check_wipers("R7");
    @(negedge clk);
    shdn_n = 1'b1;
    @(negedge clk);
    check(shutdown == 1'b0, "R7", "flag cleared", int'(shutdown), 0);
    check_sdo("R7");
    check_wipers("R7");

    // R9: two-device chain, twenty clocks under one select
    select_low();
    send_word({2'd3, 8'h9A}, "R9");
    for (int i = 9; i >= 0; i--) begin
      logic first_bit;
      first_bit = m_sr[9];
      sclk_bit(((10'({2'd1, 8'h6E}) >> i) & 10'd1) != 0, "R9");
      check(pull_low == ~first_bit, "R9", "first word on sdo",
            int'(pull_low), int'(~first_bit));
    end
    select_high_load();
    check(wiper[15:8] == 8'h6E, "R9", "second word loaded", int'(wiper[15:8]), 8'h6E);
    check(wiper[31:24] == 8'hFF, "R9", "first word not loaded", int'(wiper[31:24]), 8'hFF);

    // R8: reset arriving with the select edge wins
    select_low();
    send_word({2'd2, 8'h11}, "R6");
    @(negedge clk);
    cs_n = 1'b1;
    rs_n = 1'b0;
    wait_neg(HOLD);
    model_reset();
    check_wipers("R8");
    @(negedge clk);
    rs_n = 1'b1;
    wait_neg(HOLD);
    check_wipers("R8");
    check(pull_low == 1'b1, "R1", "latch cleared after reset", int'(pull_low), 1);

    finish_run();
  end

endmodule